// File: doc/BRIEF.md
# Protected-Mode Segment Load Checker

This block validates a selector that is being loaded into a data-type or stack segment register of a segmented, privilege-ringed processor. A single start strobe hands it a 16-bit selector, the current privilege level and a flag that marks the stack register as the target. The block then chooses the global or the local descriptor table, checks the descriptor's offset against that table's limit and fetches the eight-byte descriptor as two 32-bit reads. It applies type, privilege and presence rules and, if the descriptor has not been touched before, writes its high word back with the accessed bit set.

The block finishes with a one-cycle done pulse. With that pulse comes either a fault (general-protection, stack or not-present) with an error code, or the decoded segment base, expanded limit and attribute bits. Memory is reached through one 32-bit request/acknowledge port, and only one access is outstanding at a time.

Top module: `segLoadCheck`

## Requirements
- R1: A selector with bits 15:2 all zero is null. For a non-stack target it completes as a load with base 0, limit 0 and attributes 0 and no memory access. For the stack target it completes as a general-protection fault with error code 0 and no memory access.
- R2: Selector bit 2 set selects the local table (ldtBase/ldtLimit); clear selects the global table. The descriptor byte offset is the selector with bits 2:0 forced to zero.
- R3: If offset + 7 is greater than the selected table limit, the load ends in a general-protection fault with error code selector AND 0xFFFC, and no memory access is made.
- R4: The descriptor low word is read from tableBase + offset and the high word from tableBase + offset + 4, in that order.
- R5: A descriptor whose high-word bit 12 (segment flag) is clear raises a general-protection fault.
- R6: For the stack target the descriptor must be data (high-word bit 11 clear) and writable (bit 9 set), and both the selector's bits 1:0 and the descriptor privilege (high-word bits 14:13) must equal the current privilege. Any violation raises a general-protection fault.
- R7: For a non-stack target, code (bit 11 set) without the readable bit (bit 9) raises a general-protection fault. Unless the descriptor is conforming code (bits 11 and 10 both set), the descriptor privilege must be at least the current privilege and at least the selector's bits 1:0, or a general-protection fault is raised.
- R8: If the type and privilege checks pass but the present bit (high-word bit 15) is clear, the fault is stack-fault for the stack target and not-present otherwise. Every fault reports error code selector AND 0xFFFC, and the descriptor checks take priority over the present bit.
- R9: On a successful load whose high-word bit 8 (accessed) is clear, the high word with bit 8 set is written back to tableBase + offset + 4 before done. No write happens when bit 8 is already set or when the load faults.
- R10: The limit is {high[19:16], low[15:0]}. When high-word bit 23 is set, the reported limit becomes that value shifted left by 12 with 0xFFF in the low bits.
- R11: The base is {high[31:24], high[7:0], low[31:16]}. The attribute output is {high[23:20], high[15:9], 1'b1}, so it reflects the accessed bit as set.
- R12: Done is a one-cycle pulse, and exactly one of faultValid and loadValid is high with it. Neither is high without done. Fault codes are 0 general-protection, 1 stack-fault and 2 not-present.
- R13: Read and write are never requested together, and a request is held until memAck is seen. A successful load makes 2 or 3 accesses and a fetched fault makes 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load check (taken when idle) |
| selector | input | 16 | Selector to load |
| toStack | input | 1 | Target is the stack segment register |
| cpl | input | 2 | Current privilege level |
| gdtBase | input | ADDR_W | Global table base address |
| gdtLimit | input | TLIM_W | Global table limit in bytes |
| ldtBase | input | ADDR_W | Local table base address |
| ldtLimit | input | TLIM_W | Local table limit in bytes |
| memAddr | output | ADDR_W | Memory byte address |
| memRead | output | 1 | Read request |
| memWrite | output | 1 | Write request |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Access complete |
| done | output | 1 | Check finished (one cycle) |
| faultValid | output | 1 | Load rejected |
| faultCode | output | 2 | 0 general-protection, 1 stack-fault, 2 not-present |
| errCode | output | 16 | Fault error code |
| loadValid | output | 1 | Load accepted |
| segBase | output | 32 | Segment base |
| segLimit | output | 32 | Expanded segment limit |
| segAttr | output | 12 | Attribute bits |

## Verification
The bench builds the block with its default 32-bit addresses and 16-bit table limits. It places the global table at 0x100 with limit 0x17 and the local table at 0x200 with limit 0x0F, all inside a 256-word memory model. These small tables make every table-limit edge cheap to reach. The main sweep covers all 256 values of the descriptor's attribute byte against both targets, all four privilege levels and all four selector privilege values, which covers every type, privilege, presence and accessed-bit combination. Separate cases cover null selectors, the non-null local index 0 and the exact limit boundaries.

// File: rtl/segLoadPkg.sv
package segLoadPkg;
  localparam int WORD_W = 32;
  localparam int ACC_BIT  = 8;
  localparam int RW_BIT   = 9;
  localparam int CONF_BIT = 10;
  localparam int CODE_BIT = 11;
  localparam int SEG_BIT  = 12;
  localparam int DPL_LO   = 13;
  localparam int PRES_BIT = 15;
  localparam int GRAN_BIT = 23;

  typedef enum logic [1:0] {
    FLT_GP = 2'd0,
    FLT_SS = 2'd1,
    FLT_NP = 2'd2
  } faultKind_e;

  typedef struct packed {
    logic       capture;
    logic       takeLo;
    logic       takeHi;
    logic       addrHi;
    logic       endFault;
    faultKind_e kind;
    logic       endLoad;
    logic       endNull;
  } pathCmd_t;

  typedef struct packed {
    logic       isNull;
    logic       limitBad;
    logic       descBad;
    faultKind_e descKind;
    logic       accClear;
    logic       toStack;
  } pathStat_t;
endpackage

// File: rtl/segLoadPath.sv
module segLoadPath
  import segLoadPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TLIM_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  pathCmd_t            cmd,
  input  logic [15:0]         selIn,
  input  logic                stackIn,
  input  logic [1:0]          cplIn,
  input  logic [ADDR_W-1:0]   gdtBase,
  input  logic [TLIM_W-1:0]   gdtLimit,
  input  logic [ADDR_W-1:0]   ldtBase,
  input  logic [TLIM_W-1:0]   ldtLimit,
  input  logic [WORD_W-1:0]   memRdata,
  output pathStat_t           stat,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [WORD_W-1:0]   memWdata,
  output logic                done,
  output logic                faultValid,
  output logic [1:0]          faultCode,
  output logic [15:0]         errCode,
  output logic                loadValid,
  output logic [31:0]         segBase,
  output logic [31:0]         segLimit,
  output logic [11:0]         segAttr
);
  localparam int CMP_W = ((TLIM_W > 16) ? TLIM_W : 16) + 1;

  logic [15:0]        selQ;
  logic               stackQ;
  logic [1:0]         cplQ;
  logic [ADDR_W-1:0]  tblBaseQ;
  logic [TLIM_W-1:0]  tblLimitQ;
  logic [WORD_W-1:0]  loW, hiW;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0; stackQ <= 1'b0; cplQ <= '0;
      tblBaseQ <= '0; tblLimitQ <= '0; loW <= '0; hiW <= '0;
    end else begin
      if (cmd.capture) begin
        selQ      <= selIn;
        stackQ    <= stackIn;
        cplQ      <= cplIn;
        tblBaseQ  <= selIn[2] ? ldtBase : gdtBase;
        tblLimitQ <= selIn[2] ? ldtLimit : gdtLimit;
      end
      if (cmd.takeLo) loW <= memRdata;
      if (cmd.takeHi) hiW <= memRdata;
    end
  end

  // table offset and limit test
  logic [15:0]       offs;
  logic [CMP_W-1:0]  endOff;
  logic [ADDR_W-1:0] descAddr;
  assign offs     = {selQ[15:3], 3'b000};
  assign endOff   = CMP_W'(offs) + CMP_W'(7);
  assign descAddr = tblBaseQ + ADDR_W'(offs);
  assign memAddr  = descAddr + (cmd.addrHi ? ADDR_W'(4) : ADDR_W'(0));
  assign memWdata = hiW | (WORD_W'(1) << ACC_BIT);

  // descriptor rules
  logic [1:0] dpl, rpl;
  logic isCode, canRw, isConf, privFail, typeBad;
  assign dpl    = hiW[DPL_LO +: 2];
  assign rpl    = selQ[1:0];
  assign isCode = hiW[CODE_BIT];
  assign canRw  = hiW[RW_BIT];
  assign isConf = hiW[CONF_BIT];

  always_comb begin
    if (stackQ)
      typeBad = isCode || !canRw || (rpl != cplQ) || (dpl != cplQ);
    else
      typeBad = (isCode && !canRw) ||
                (!(isCode && isConf) && ((dpl < cplQ) || (dpl < rpl)));
    privFail = !hiW[SEG_BIT] || typeBad;
  end

  assign stat.isNull   = (selQ[15:2] == '0);
  assign stat.limitBad = endOff > CMP_W'(tblLimitQ);
  assign stat.descBad  = privFail || !hiW[PRES_BIT];
  assign stat.descKind = privFail ? FLT_GP : (stackQ ? FLT_SS : FLT_NP);
  assign stat.accClear = !hiW[ACC_BIT];
  assign stat.toStack  = stackQ;

  // decoded segment fields
  logic [19:0] lim20;
  assign lim20 = {hiW[19:16], loW[15:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0; faultValid <= 1'b0; loadValid <= 1'b0;
      faultCode <= '0; errCode <= '0;
      segBase <= '0; segLimit <= '0; segAttr <= '0;
    end else begin
      done       <= cmd.endFault || cmd.endLoad || cmd.endNull;
      faultValid <= cmd.endFault;
      loadValid  <= cmd.endLoad || cmd.endNull;
      if (cmd.endFault) begin
        faultCode <= cmd.kind;
        errCode   <= selQ & 16'hFFFC;
      end
      if (cmd.endNull) begin
        segBase <= '0; segLimit <= '0; segAttr <= '0;
      end else if (cmd.endLoad) begin
        segBase  <= {hiW[31:24], hiW[7:0], loW[31:16]};
        segLimit <= hiW[GRAN_BIT] ? {lim20, 12'hFFF} : {12'h000, lim20};
        segAttr  <= {hiW[23:20], hiW[15:9], 1'b1};
      end
    end
  end

  a_r12_one_result: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (faultValid != loadValid));
  a_r12_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (!faultValid && !loadValid));
  a_r8_err_aligned: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> (errCode[1:0] == 2'b00));
  a_r6_stack_rights: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && stackQ) |-> (selQ[1:0] == cplQ && segAttr[6:5] == cplQ));
  a_r7_data_rights: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && !stackQ && segAttr[4] && !(segAttr[3] && segAttr[2]))
      |-> (segAttr[6:5] >= cplQ && segAttr[6:5] >= selQ[1:0]));
  a_r1_null_empty: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && selQ[15:2] == '0) |-> (segBase == '0 && segLimit == '0));
endmodule

// File: rtl/segLoadCtrl.sv
module segLoadCtrl
  import segLoadPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  pathStat_t stat,
  input  logic      memAck,
  output pathCmd_t  cmd,
  output logic      memRead,
  output logic      memWrite
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_RDLO, ST_RDHI, ST_CHECK, ST_WRHI
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    cmd       = '0;
    cmd.kind  = FLT_GP;
    memRead   = 1'b0;
    memWrite  = 1'b0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (start) begin
        cmd.capture = 1'b1;
        nextState   = ST_EVAL;
      end
      ST_EVAL: begin
        if (stat.isNull) begin
          if (stat.toStack) cmd.endFault = 1'b1;
          else              cmd.endNull  = 1'b1;
          nextState = ST_IDLE;
        end else if (stat.limitBad) begin
          cmd.endFault = 1'b1;
          nextState    = ST_IDLE;
        end else begin
          nextState = ST_RDLO;
        end
      end
      ST_RDLO: begin
        memRead = 1'b1;
        if (memAck) begin
          cmd.takeLo = 1'b1;
          nextState  = ST_RDHI;
        end
      end
      ST_RDHI: begin
        memRead    = 1'b1;
        cmd.addrHi = 1'b1;
        if (memAck) begin
          cmd.takeHi = 1'b1;
          nextState  = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (stat.descBad) begin
          cmd.endFault = 1'b1;
          cmd.kind     = stat.descKind;
          nextState    = ST_IDLE;
        end else if (stat.accClear) begin
          nextState = ST_WRHI;
        end else begin
          cmd.endLoad = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      ST_WRHI: begin
        memWrite   = 1'b1;
        cmd.addrHi = 1'b1;
        if (memAck) begin
          cmd.endLoad = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  a_r13_one_access: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));
  a_r13_read_held: assert property (@(posedge clk) disable iff (!rstN)
    (memRead && !memAck) |=> memRead);
  a_r3_no_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EVAL && (stat.isNull || stat.limitBad)) |=> !memRead);
  a_r9_write_ok_only: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> !stat.descBad);
endmodule

// File: rtl/segLoadCheck.sv
module segLoadCheck
  import segLoadPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TLIM_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [15:0]       selector,
  input  logic              toStack,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] gdtBase,
  input  logic [TLIM_W-1:0] gdtLimit,
  input  logic [ADDR_W-1:0] ldtBase,
  input  logic [TLIM_W-1:0] ldtLimit,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRead,
  output logic              memWrite,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic              done,
  output logic              faultValid,
  output logic [1:0]        faultCode,
  output logic [15:0]       errCode,
  output logic              loadValid,
  output logic [31:0]       segBase,
  output logic [31:0]       segLimit,
  output logic [11:0]       segAttr
);
  pathCmd_t  cmd;
  pathStat_t stat;

  segLoadCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat), .memAck(memAck),
    .cmd(cmd), .memRead(memRead), .memWrite(memWrite)
  );

  segLoadPath #(.ADDR_W(ADDR_W), .TLIM_W(TLIM_W)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .selIn(selector), .stackIn(toStack), .cplIn(cpl),
    .gdtBase(gdtBase), .gdtLimit(gdtLimit),
    .ldtBase(ldtBase), .ldtLimit(ldtLimit),
    .memRdata(memRdata), .stat(stat),
    .memAddr(memAddr), .memWdata(memWdata),
    .done(done), .faultValid(faultValid), .faultCode(faultCode),
    .errCode(errCode), .loadValid(loadValid),
    .segBase(segBase), .segLimit(segLimit), .segAttr(segAttr)
  );
endmodule

// File: tb/segLoadCheck_test.sv
module segLoadCheck_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] selector = '0;
  logic        toStack = 1'b0;
  logic [1:0]  cpl = '0;
  logic [31:0] gdtBase = 32'h100, ldtBase = 32'h200;
  logic [15:0] gdtLimit = 16'h17, ldtLimit = 16'h0F;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memRead, memWrite;
  logic        memAck = 1'b0;
  logic        done, faultValid, loadValid;
  logic [1:0]  faultCode;
  logic [15:0] errCode;
  logic [31:0] segBase, segLimit;
  logic [11:0] segAttr;

  int checks = 0, errors = 0;
  int accTotal = 0, wrTotal = 0;
  bit finished = 1'b0;

  logic [31:0] mem [0:255];
  logic        pWe = 1'b0;
  logic [7:0]  pIdx = '0;
  logic [31:0] pData = '0;

  segLoadCheck uut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (pWe) mem[pIdx] <= pData;
    if (!rstN) memAck <= 1'b0;
    else if ((memRead || memWrite) && !memAck) begin
      memAck   <= 1'b1;
      accTotal <= accTotal + 1;
      if (memWrite) begin
        mem[memAddr[9:2]] <= memWdata;
        wrTotal <= wrTotal + 1;
      end else memRdata <= mem[memAddr[9:2]];
    end else memAck <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic putDesc(input int word, input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk); pWe = 1'b1; pIdx = 8'(word);     pData = lo;
    @(negedge clk);             pIdx = 8'(word + 1); pData = hi;
    @(negedge clk); pWe = 1'b0;
  endtask

  int accUsed, wrUsed;
  task automatic runLoad(input logic [15:0] sel, input logic stk, input logic [1:0] cp);
    int a0, w0, cyc;
    @(negedge clk);
    a0 = accTotal; w0 = wrTotal;
    selector = sel; toStack = stk; cpl = cp; start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 40) begin @(negedge clk); cyc++; end
    chk(done === 1'b1, "R12", "done pulse", 64'(done), 64'd1);
    chk((faultValid ^ loadValid) === 1'b1, "R12", "one result", 64'({faultValid, loadValid}), 64'd1);
    accUsed = accTotal - a0; wrUsed = wrTotal - w0;
  endtask

  task automatic expectFault(input string req, input logic [1:0] code,
                             input logic [15:0] sel, input int acc);
    chk(faultValid === 1'b1, req, "faultValid", 64'(faultValid), 64'd1);
    chk(faultCode === code, req, "faultCode", 64'(faultCode), 64'(code));
    chk(errCode === (sel & 16'hFFFC), req, "errCode", 64'(errCode), 64'(sel & 16'hFFFC));
    chk(accUsed == acc, "R13", "access count", 64'(accUsed), 64'(acc));
    chk(wrUsed == 0, "R9", "no write on fault", 64'(wrUsed), 64'd0);
  endtask

  task automatic expectLoad(input logic [31:0] lo, input logic [31:0] hi, input int word);
    logic [19:0] l20;
    logic [31:0] eLim, eBase;
    logic [11:0] eAttr;
    int needWr;
    l20   = {hi[19:16], lo[15:0]};
    eLim  = hi[23] ? {l20, 12'hFFF} : {12'h0, l20};
    eBase = {hi[31:24], hi[7:0], lo[31:16]};
    eAttr = {hi[23:20], hi[15:9], 1'b1};
    needWr = hi[8] ? 0 : 1;
    chk(loadValid === 1'b1, "R12", "loadValid", 64'(loadValid), 64'd1);
    chk(segBase === eBase, "R11", "base", 64'(segBase), 64'(eBase));
    chk(segLimit === eLim, "R10", "limit", 64'(segLimit), 64'(eLim));
    chk(segAttr === eAttr, "R11", "attr", 64'(segAttr), 64'(eAttr));
    chk(wrUsed == needWr, "R9", "write count", 64'(wrUsed), 64'(needWr));
    chk(mem[word + 1] === (hi | 32'h100), "R9", "stored high word", 64'(mem[word + 1]), 64'(hi | 32'h100));
    chk(accUsed == 2 + needWr, "R4", "access count", 64'(accUsed), 64'(2 + needWr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state (R12)
    chk(!done && !faultValid && !loadValid, "R12", "reset outputs",
        64'({done, faultValid, loadValid}), 64'd0);
    chk(!memRead && !memWrite, "R13", "reset memory idle", 64'({memRead, memWrite}), 64'd0);

    // null selectors (R1)
    for (int s = 0; s < 4; s++) begin
      runLoad(16'(s), 1'b0, 2'(s));
      chk(loadValid && segBase == 0 && segLimit == 0 && segAttr == 0, "R1", "null empty load",
          64'({loadValid, segBase}), 64'h1_0000_0000);
      chk(accUsed == 0, "R1", "null no access", 64'(accUsed), 64'd0);
      runLoad(16'(s), 1'b1, 2'(s));
      expectFault("R1", 2'd0, 16'(s), 0);
    end

    // table select and offset (R2): distinct descriptors in GDT index 1 and LDT index 0/1
    putDesc(64 + 2, 32'h1111_FFFF, 32'h0000_F300);
    putDesc(128 + 0, 32'h2222_0001, 32'h0000_F300);
    putDesc(128 + 2, 32'h3333_0002, 32'h0000_F300);
    runLoad(16'h000B, 1'b0, 2'd3);
    chk(segBase === 32'h0000_1111, "R2", "GDT index 1 base", 64'(segBase), 64'h1111);
    runLoad(16'h0007, 1'b0, 2'd3);
    chk(segBase === 32'h0000_2222, "R2", "LDT index 0 not null", 64'(segBase), 64'h2222);
    runLoad(16'h000F, 1'b0, 2'd3);
    chk(segBase === 32'h0000_3333, "R2", "LDT index 1 base", 64'(segBase), 64'h3333);

    // limit boundaries (R3)
    putDesc(64 + 4, 32'h4444_0010, 32'h0000_F300);
    runLoad(16'h0013, 1'b0, 2'd3);
    chk(loadValid === 1'b1, "R3", "offset+7 == limit allowed", 64'(loadValid), 64'd1);
    runLoad(16'h001B, 1'b0, 2'd3);
    expectFault("R3", 2'd0, 16'h001B, 0);
    gdtLimit = 16'h16;
    runLoad(16'h0013, 1'b0, 2'd3);
    expectFault("R3", 2'd0, 16'h0013, 0);
    gdtLimit = 16'h17;
    runLoad(16'h0016, 1'b1, 2'd2);
    expectFault("R3", 2'd0, 16'h0016, 0);

    // exhaustive attribute x target x privilege sweep (R4..R11)
    for (int a = 0; a < 256; a++) begin
      for (int st = 0; st < 2; st++) begin
        for (int cp = 0; cp < 4; cp++) begin
          for (int rp = 0; rp < 4; rp++) begin
            int idx, word;
            logic useLdt;
            logic [15:0] sel;
            logic [31:0] lo, hi;
            logic [7:0] at;
            logic [1:0] dp;
            logic gp;
            string req;
            idx = a * 32 + st * 16 + cp * 4 + rp;
            useLdt = idx[0] ^ idx[5];
            sel  = useLdt ? (16'h000C | 16'(rp)) : (16'h0010 | 16'(rp));
            word = useLdt ? 130 : 68;
            at = 8'(a);
            lo = 32'h1357_2468 ^ (32'(idx) * 32'h0009_E377);
            hi = {8'(idx * 3), idx[6], idx[10:8], 4'(idx >> 2), at, 8'(idx) ^ 8'h5A};
            putDesc(word, lo, hi);
            runLoad(sel, st[0], 2'(cp));
            dp = at[6:5];
            gp = 1'b0;
            req = "R7";
            if (!at[4]) begin gp = 1'b1; req = "R5"; end
            else if (st != 0) begin
              req = "R6";
              gp = at[3] || !at[1] || (2'(rp) != 2'(cp)) || (dp != 2'(cp));
            end else begin
              if (at[3] && !at[1]) gp = 1'b1;
              if (!(at[3] && at[2]) && (dp < 2'(cp) || dp < 2'(rp))) gp = 1'b1;
            end
            if (gp) expectFault(req, 2'd0, sel, 2);
            else if (!at[7]) expectFault("R8", (st != 0) ? 2'd1 : 2'd2, sel, 2);
            else expectLoad(lo, hi, word);
          end
        end
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule